// File: doc/BRIEF.md
# Byte-Addressed Memory with Character Output Port

This block is the single memory space of a small processor. Storage is a flat array of 8-bit cells. Requesters reach it through one request port with a byte address and an access size of one, two or four bytes. Values wider than a byte are built from consecutive cells, lowest address first, and a single request of any size and alignment completes in one cycle. The intended configuration uses a 16-bit address, which gives 64 KB of cells. Software splits that space into a 4 KB program area at the bottom (0x0000 to 0x0FFF), a 56 KB data area (0x1000 to 0xEFFF) and a 4 KB stack area at the top (0xF000 to 0xFFFF). The block itself treats all cells the same way.

One address, the base of the highest 256-byte page (0xFF00 with a 16-bit address), is an output register. A 32-bit write to it stores nothing. Its low byte is sent out as a character on a valid/ready stream instead. While the stream is not ready, the write is not acknowledged. The address width is a parameter. The default of 12 bits keeps the array small for elaboration, and 16 bits gives the full 64 KB space.

Top module: `bytemem`

## Requirements
- R1: After reset, with no request pending, rd_valid and char_valid are both low.
- R2: A byte read (size code 0) returns the stored byte in rd_data[7:0] with rd_data[31:8] zero. It appears in the cycle after the request is accepted.
- R3: Multi-byte values are little-endian. A write of size 1 or 2 at address A puts bits 7:0 at A, bits 15:8 at A+1 and so on. Cells outside the access size are left unchanged.
- R4: Half-word (size code 1) and word (size code 2) reads start at any byte address, with no alignment restriction. They return the consecutive cells zero-extended, with the lowest address in the least significant byte.
- R5: An access whose bytes run past the highest address wraps to address 0 and continues from there.
- R6: A write of size code 2 or 3 whose address equals the output address leaves the array unchanged. It raises char_valid, with char_data equal to req_wdata[7:0], in the same cycle.
- R7: A read of any size whose start address equals the output address returns zero.
- R8: While an output write is presented and char_ready is low, req_ready is low and nothing is stored. Once char_ready rises, req_ready rises in that same cycle.
- R9: Byte and half-word writes to the output address are not intercepted. They store into the array like any other address.
- R10: rd_valid is high exactly in the cycle after each accepted read, including back-to-back reads, and is low after an accepted write.
- R11: Size code 3 behaves as a 32-bit access for both reads and writes.
- R12: All requests other than output-port writes are accepted at once: req_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 byte, 1 half-word, 2 or 3 word |
| req_addr | input | ADDR_W | Byte address of the lowest cell |
| req_wdata | input | 32 | Write value, least significant byte at the lowest address |
| req_ready | output | 1 | Request accepted this cycle |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 32 | Read value, zero-extended |
| char_valid | output | 1 | Character present on the output stream |
| char_data | output | 8 | Character value |
| char_ready | input | 1 | Output stream can take a character |

## Verification
The bench builds the block with a 12-bit address. This makes the array 4 KB and puts the output register at 0xF00. With this size the bench can fill every cell before the random phase, so each random read checks against known contents. The wrap from 0xFFF to 0x000 and the accesses that straddle the output register also come within reach of directed tests. The random phase mixes every size code at unaligned addresses.

// File: rtl/bytemem_pkg.sv
package bytemem_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_WIDE = 2'd3
  } size_e;

  // number of cells touched by an access of the given size code
  function automatic logic [2:0] access_bytes(input logic [1:0] sz);
    case (sz)
      SZ_BYTE: return 3'd1;
      SZ_HALF: return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  // which byte of the access lands in a given bank, for a start offset lo
  function automatic logic [1:0] lane_slot(input logic [1:0] bank, input logic [1:0] lo);
    return bank - lo;
  endfunction

  // true when the byte at slot k, starting at offset lo, falls in the next row
  function automatic logic row_carry(input logic [1:0] lo, input logic [1:0] k);
    return ({1'b0, lo} + {1'b0, k}) > 3'd3;
  endfunction

endpackage

// File: rtl/bytemem_bank.sv
module bytemem_bank #(
  parameter int ROW_W = 10
) (
  input  logic             clk,
  input  logic             we,
  input  logic [ROW_W-1:0] row,
  input  logic [7:0]       wbyte,
  output logic [7:0]       q
);
  localparam int DEPTH = 1 << ROW_W;

  logic [7:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[row] <= wbyte;
    q <= cells[row];
  end
endmodule

// File: rtl/bytemem_outport.sv
module bytemem_outport #(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] PORT_ADDR = '0
) (
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              wide_size,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [7:0]        wbyte,
  input  logic              char_ready,
  output logic              intercept,
  output logic              req_ready,
  output logic              char_valid,
  output logic [7:0]        char_data
);
  assign intercept  = req_valid && req_write && wide_size && (req_addr == PORT_ADDR);
  assign char_valid = intercept;
  assign char_data  = wbyte;
  assign req_ready  = !intercept || char_ready;
endmodule

// File: rtl/bytemem.sv
module bytemem #(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [1:0]        req_size,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic              req_ready,
  output logic              rd_valid,
  output logic [31:0]       rd_data,
  output logic              char_valid,
  output logic [7:0]        char_data,
  input  logic              char_ready
);
  import bytemem_pkg::*;

  localparam int LANES = 4;
  localparam int ROW_W = ADDR_W - 2;
  localparam logic [ADDR_W-1:0] PORT_ADDR = ADDR_W'((1 << ADDR_W) - 256);

  logic              intercept;
  logic              fire;
  logic [2:0]        nbytes;
  logic [LANES-1:0]  bank_we;
  logic [LANES-1:0][7:0] bank_q;

  bytemem_outport #(.ADDR_W(ADDR_W), .PORT_ADDR(PORT_ADDR)) u_out (
    .req_valid (req_valid),
    .req_write (req_write),
    .wide_size (req_size[1]),
    .req_addr  (req_addr),
    .wbyte     (req_wdata[7:0]),
    .char_ready(char_ready),
    .intercept (intercept),
    .req_ready (req_ready),
    .char_valid(char_valid),
    .char_data (char_data)
  );

  assign fire   = req_valid && req_ready;
  assign nbytes = access_bytes(req_size);

  for (genvar b = 0; b < LANES; b++) begin : g_lane
    logic [1:0]       slot;
    logic             active;
    logic [ROW_W-1:0] row;
    logic [7:0]       wbyte;

    assign slot   = lane_slot(2'(b), req_addr[1:0]);
    assign active = {1'b0, slot} < nbytes;
    assign row    = req_addr[ADDR_W-1:2] + ROW_W'(row_carry(req_addr[1:0], slot));
    assign wbyte  = req_wdata[8*slot +: 8];
    assign bank_we[b] = fire && req_write && !intercept && active;

    bytemem_bank #(.ROW_W(ROW_W)) u_bank (
      .clk  (clk),
      .we   (bank_we[b]),
      .row  (row),
      .wbyte(wbyte),
      .q    (bank_q[b])
    );
  end

  // read metadata, one stage to line up with the bank outputs
  logic       rd_valid_q;
  logic [1:0] lo_q;
  logic [1:0] size_q;
  logic       zero_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid_q <= 1'b0;
      lo_q       <= '0;
      size_q     <= '0;
      zero_q     <= 1'b0;
    end else begin
      rd_valid_q <= fire && !req_write;
      lo_q       <= req_addr[1:0];
      size_q     <= req_size;
      zero_q     <= req_addr == PORT_ADDR;
    end
  end

  assign rd_valid = rd_valid_q;

  always_comb begin
    rd_data = '0;
    for (int k = 0; k < LANES; k++) begin
      if (!zero_q && (3'(k) < access_bytes(size_q)))
        rd_data[8*k +: 8] = bank_q[2'(lo_q + 2'(k))];
    end
  end

  // ---------------- assertions ----------------
  assert_port_no_store_R6: assert property (@(posedge clk) disable iff (!rst_n)
    intercept |-> (bank_we == '0));

  assert_stall_no_store_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |-> (bank_we == '0));

  assert_lane_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(bank_we) <= int'(access_bytes(req_size)));

  assert_rd_timing_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_write) |=> rd_valid);

  assert_port_read_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_write && req_addr == PORT_ADDR) |=> (rd_data == '0));

  assert_byte_zext_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_write && req_size == 2'd0) |=> (rd_data[31:8] == '0));

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> !char_valid);
endmodule

// File: tb/bytemem_tb.sv
module bytemem_tb_top;
  localparam int AW    = 12;
  localparam int MSZ   = 1 << AW;
  localparam int MASK  = MSZ - 1;
  localparam int PORT  = MSZ - 256;

  logic          clk = 0;
  logic          rst_n = 0;
  logic          req_valid = 0, req_write = 0;
  logic [1:0]    req_size = 0;
  logic [AW-1:0] req_addr = 0;
  logic [31:0]   req_wdata = 0;
  logic          req_ready, rd_valid, char_valid;
  logic [31:0]   rd_data;
  logic [7:0]    char_data;
  logic          char_ready = 1;

  always #5 clk = ~clk;

  bytemem #(.ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_ready(req_ready), .rd_valid(rd_valid), .rd_data(rd_data),
    .char_valid(char_valid), .char_data(char_data), .char_ready(char_ready)
  );

  logic [7:0] model [MSZ];
  int total = 0, fails = 0, cyc = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int nb(input logic [1:0] sz);
    return (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
  endfunction

  function automatic logic [31:0] exp_read(input logic [1:0] sz, input int a);
    logic [31:0] v = 0;
    if (a == PORT) return 0;
    for (int k = 0; k < nb(sz); k++) v[8*k +: 8] = model[(a + k) & MASK];
    return v;
  endfunction

  task automatic do_op(input bit wr, input logic [1:0] sz, input int a, input logic [31:0] d, input string tag);
    logic [31:0] e;
    bit hit;
    @(negedge clk);
    req_valid = 1; req_write = wr; req_size = sz; req_addr = AW'(a); req_wdata = d;
    #1;
    hit = wr && sz[1] && (a == PORT);
    e = exp_read(sz, a);
    if (hit) check(char_valid && char_data == d[7:0], {tag, " R6 char"}, {24'h0, char_data}, {24'h0, d[7:0]});
    else check(req_ready && !char_valid, {tag, " R12 ready"}, {30'h0, req_ready, char_valid}, 32'h2);
    while (!req_ready) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    if (!wr) begin
      check(rd_valid && rd_data == e, {tag, " R10 read"}, rd_data, e);
    end else begin
      check(!rd_valid, {tag, " R10 no rd_valid after write"}, {31'h0, rd_valid}, 0);
      if (!hit) for (int k = 0; k < nb(sz); k++) model[(a + k) & MASK] = d[8*k +: 8];
    end
  endtask

  task automatic idle();
    @(negedge clk); req_valid = 0; req_write = 0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      finished = 1;
      total++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    #1;
    check(!rd_valid && !char_valid, "R1 reset state", {30'h0, rd_valid, char_valid}, 0);
    @(negedge clk); rst_n = 1;
    @(posedge clk); #1;
    check(!rd_valid && !char_valid, "R1 after release", {30'h0, rd_valid, char_valid}, 0);

    // fill all cells (the output address takes byte writes, which R9 says store)
    for (int a = 0; a < MSZ; a += 4) begin
      if (a == PORT) for (int k = 0; k < 4; k++) do_op(1, 2'd0, a + k, $urandom, "R9 fill");
      else do_op(1, 2'd2, a, $urandom, "fill");
    end

    // R3 little-endian layout
    do_op(1, 2'd2, 'h100, 32'h11223344, "R3 word write");
    do_op(0, 2'd0, 'h100, 0, "R3 byte0");
    do_op(0, 2'd0, 'h103, 0, "R3 byte3");
    do_op(1, 2'd1, 'h200, 32'hFFFFBEEF, "R3 half write");
    do_op(0, 2'd2, 'h1FF, 0, "R3 half neighbours");
    // R2 zero extension
    do_op(0, 2'd0, 'h101, 0, "R2 byte read");
    // R4 unaligned
    do_op(0, 2'd2, 'h101, 0, "R4 word at +1");
    do_op(0, 2'd1, 'h103, 0, "R4 half crossing");
    do_op(0, 2'd2, 'h102, 0, "R4 word at +2");
    // R5 wrap
    do_op(1, 2'd2, MSZ - 2, 32'hAABBCCDD, "R5 wrap write");
    do_op(0, 2'd0, 0, 0, "R5 byte at 0");
    do_op(0, 2'd2, MSZ - 1, 0, "R5 wrap word read");
    // R6 output port
    do_op(1, 2'd2, PORT, 32'h12345641, "R6 emit");
    do_op(0, 2'd2, PORT - 1, 0, "R6 storage kept");
    // R7
    do_op(0, 2'd2, PORT, 0, "R7 port word read");
    do_op(0, 2'd0, PORT, 0, "R7 port byte read");
    // R9 byte write at port stores
    do_op(1, 2'd0, PORT, 32'h0000005A, "R9 byte store");
    do_op(0, 2'd1, PORT - 1, 0, "R9 readback");
    // R11 size code 3
    do_op(1, 2'd3, 'h301, 32'hCAFEF00D, "R11 write");
    do_op(0, 2'd2, 'h301, 0, "R11 read as 2");
    do_op(0, 2'd3, 'h302, 0, "R11 read as 3");
    do_op(1, 2'd3, PORT, 32'h00000042, "R11 R6 emit");
    idle();

    // R8 stall
    @(negedge clk);
    char_ready = 0;
    req_valid = 1; req_write = 1; req_size = 2'd2; req_addr = AW'(PORT); req_wdata = 32'h00000037;
    #1;
    check(!req_ready && char_valid && char_data == 8'h37, "R8 stalled", {23'h0, req_ready, char_data}, 32'h37);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); #1;
      check(!req_ready, "R8 still stalled", {31'h0, req_ready}, 0);
    end
    @(negedge clk); char_ready = 1; #1;
    check(req_ready, "R8 released", {31'h0, req_ready}, 1);
    @(posedge clk);
    idle();
    do_op(0, 2'd2, PORT - 1, 0, "R8 no store");

    // R10 back-to-back reads
    do_op(0, 2'd0, 'h100, 0, "R10 b2b 1");
    do_op(0, 2'd1, 'h101, 0, "R10 b2b 2");
    idle();
    @(posedge clk); #1;
    check(!rd_valid, "R10 idle low", {31'h0, rd_valid}, 0);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      logic [1:0] sz = 2'($urandom_range(0, 3));
      int a = int'($urandom & MASK);
      bit wr = 1'($urandom_range(0, 1));
      if ($urandom_range(0, 30) == 0) a = PORT - int'($urandom_range(0, 2));
      do_op(wr, sz, a, $urandom, "R4 random");
    end
    idle();

    finished = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule